// File: doc/BRIEF.md
# Answer-to-Reset Window Timer

This block supervises the timing of a smart card's first response. The host pulses a release strobe when the card's reset line is let go. From the next card clock edge a counter measures how long the card takes to send the leading start bit of its answer-to-reset. A start bit that arrives too soon is flagged as an early answer and is refused. A start bit inside the acceptance window is accepted, and the timer then goes quiet. If the window closes with no answer, the card is declared mute.

The same counter also supervises waiting time once the session is running. The host writes a 24-bit reload value and arms waiting mode. The counter then counts down, and every start bit the UART reports reloads it. If the counter reaches zero first, a timeout is raised. Both error flags are sticky, and the interrupt line stays high until the host reads status. A stop command ends any supervision quietly.

Top module: `atr_window_timer`

## Requirements
- R1: After reset, atr_ok, early_flag, timeout_flag and irq are all 0.
- R2: Number the card clock edges after the edge that samples release_stb as 1, 2, 3 and so on. A start_bit sampled at edge k, with EARLY_CLKS <= k < LATE_CLKS, makes atr_ok high for exactly the one cycle after that edge. Supervision then stops, so no timeout follows.
- R3: A start_bit sampled at edge k < EARLY_CLKS sets early_flag and leaves atr_ok at 0. Supervision goes on, and a later start bit inside the window is still accepted.
- R4: If no start bit has been accepted by edge LATE_CLKS, timeout_flag sets at that edge. A start bit sampled exactly at edge LATE_CLKS is not accepted.
- R5: wt_start loads the counter from the reload register, which is written by wr_reload/wr_data at least one cycle before. If no start bit arrives, timeout_flag sets at edge max(reload,1) after the arming edge.
- R6: In waiting mode, each start_bit reloads the counter. The timeout then comes max(reload,1) edges after the last start bit.
- R7: early_flag and timeout_flag stay set until stat_rd is sampled high, which clears them. When a flag is being set in the same cycle as stat_rd, the set wins.
- R8: stop_cmd ends supervision without setting any flag. A start bit that comes afterwards gives neither atr_ok nor early_flag.
- R9: irq is high exactly when early_flag or timeout_flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| release_stb | input | 1 | Card reset line released; starts window supervision |
| start_bit | input | 1 | Start bit detected by the UART (one-cycle pulse) |
| stop_cmd | input | 1 | Halt any supervision without flags |
| wt_start | input | 1 | Arm waiting-time supervision from the reload register |
| wr_reload | input | 1 | Write strobe for the reload register |
| wr_data | input | CNT_W | Reload value |
| stat_rd | input | 1 | Host status read; clears sticky flags |
| atr_ok | output | 1 | One-cycle pulse: answer start accepted |
| early_flag | output | 1 | Sticky: start bit arrived before the window opened |
| timeout_flag | output | 1 | Sticky: window closed or waiting time expired |
| irq | output | 1 | Interrupt, high while any sticky flag is set |

## Verification
The bench builds the timer with the full 24-bit counter, but shrinks the window to EARLY_CLKS=20 and LATE_CLKS=150. With this window, random arrival points cover the early region, the open window and the late region, and the runs stay short. The edges EARLY_CLKS-1, EARLY_CLKS, LATE_CLKS-1 and LATE_CLKS are each hit directly. Waiting mode uses small reload values, including zero, so every countdown, reload and expiry completes many times in one run.

// File: rtl/atw_pkg.sv
package atw_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_ATR  = 2'd1,
        MODE_WAIT = 2'd2
    } atw_mode_e;
endpackage

// File: rtl/atw_window_decode.sv
module atw_window_decode #(
    parameter int CNT_W      = 24,
    parameter int EARLY_CLKS = 380,
    parameter int LATE_CLKS  = 42000
) (
    input  logic [CNT_W-1:0] cnt,
    output logic             before_open,
    output logic             window_shut,
    output logic             wait_done
);
    localparam logic [CNT_W-1:0] OPEN_AT  = CNT_W'(EARLY_CLKS);
    localparam logic [CNT_W-1:0] SHUT_AT  = CNT_W'(LATE_CLKS);
    localparam logic [CNT_W-1:0] LAST_TCK = CNT_W'(1);

    always_comb begin
        before_open = (cnt < OPEN_AT);
        window_shut = (cnt >= SHUT_AT);
        wait_done   = (cnt <= LAST_TCK);
    end
endmodule

// File: rtl/atw_status.sv
module atw_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_early,
    input  logic set_tmo,
    input  logic clr,
    output logic early_q,
    output logic tmo_q,
    output logic irq
);
    typedef struct packed {
        logic early;
        logic tmo;
    } flags_t;

    flags_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (clr) begin
            flg_d.early = 1'b0;
            flg_d.tmo   = 1'b0;
        end
        if (set_early) flg_d.early = 1'b1;
        if (set_tmo)   flg_d.tmo   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign early_q = flg_q.early;
    assign tmo_q   = flg_q.tmo;
    assign irq     = flg_q.early | flg_q.tmo;
endmodule

// File: rtl/atr_window_timer.sv
module atr_window_timer
    import atw_pkg::*;
#(
    parameter int CNT_W      = 24,
    parameter int EARLY_CLKS = 380,
    parameter int LATE_CLKS  = 42000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             release_stb,
    input  logic             start_bit,
    input  logic             stop_cmd,
    input  logic             wt_start,
    input  logic             wr_reload,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             stat_rd,
    output logic             atr_ok,
    output logic             early_flag,
    output logic             timeout_flag,
    output logic             irq
);
    localparam logic [CNT_W-1:0] FIRST_EDGE = CNT_W'(1);

    typedef struct packed {
        atw_mode_e        mode;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic             ok;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic before_open, window_shut, wait_done;
    logic set_early, set_tmo;

    atw_window_decode #(
        .CNT_W     (CNT_W),
        .EARLY_CLKS(EARLY_CLKS),
        .LATE_CLKS (LATE_CLKS)
    ) u_dec (
        .cnt        (tmr_q.cnt),
        .before_open(before_open),
        .window_shut(window_shut),
        .wait_done  (wait_done)
    );

    always_comb begin
        tmr_d     = tmr_q;
        tmr_d.ok  = 1'b0;
        set_early = 1'b0;
        set_tmo   = 1'b0;
        if (wr_reload) tmr_d.reload = wr_data;

        if (stop_cmd) begin
            tmr_d.mode = MODE_IDLE;
        end else if (release_stb) begin
            tmr_d.mode = MODE_ATR;
            tmr_d.cnt  = FIRST_EDGE;
        end else if (wt_start) begin
            tmr_d.mode = MODE_WAIT;
            tmr_d.cnt  = tmr_q.reload;
        end else begin
            unique case (tmr_q.mode)
                MODE_ATR: begin
                    if (window_shut) begin
                        set_tmo    = 1'b1;
                        tmr_d.mode = MODE_IDLE;
                    end else if (start_bit && !before_open) begin
                        tmr_d.ok   = 1'b1;
                        tmr_d.mode = MODE_IDLE;
                    end else begin
                        set_early = start_bit;
                        tmr_d.cnt = tmr_q.cnt + FIRST_EDGE;
                    end
                end
                MODE_WAIT: begin
                    if (start_bit) begin
                        tmr_d.cnt = tmr_q.reload;
                    end else if (wait_done) begin
                        set_tmo    = 1'b1;
                        tmr_d.cnt  = '0;
                        tmr_d.mode = MODE_IDLE;
                    end else begin
                        tmr_d.cnt = tmr_q.cnt - FIRST_EDGE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q      <= '0;
            tmr_q.mode <= MODE_IDLE;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    atw_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_early(set_early),
        .set_tmo  (set_tmo),
        .clr      (stat_rd),
        .early_q  (early_flag),
        .tmo_q    (timeout_flag),
        .irq      (irq)
    );

    assign atr_ok = tmr_q.ok;
endmodule

// File: rtl/atw_checker.sv
module atw_checker (
    input logic clk,
    input logic rst_n,
    input logic stop_cmd,
    input logic stat_rd,
    input logic atr_ok,
    input logic early_flag,
    input logic timeout_flag,
    input logic irq
);
    p_ok_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        atr_ok |=> !atr_ok);

    p_early_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (early_flag && !stat_rd) |=> early_flag);

    p_tmo_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !stat_rd) |=> timeout_flag);

    p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cmd && !stat_rd) |=>
            (!atr_ok && early_flag == $past(early_flag)
                     && timeout_flag == $past(timeout_flag)));

    p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (early_flag || timeout_flag));

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |-> (!atr_ok && !early_flag && !timeout_flag && !irq));
endmodule

bind atr_window_timer atw_checker u_atw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_cmd    (stop_cmd),
    .stat_rd     (stat_rd),
    .atr_ok      (atr_ok),
    .early_flag  (early_flag),
    .timeout_flag(timeout_flag),
    .irq         (irq)
);

// File: tb/atr_window_timer_test.sv
`timescale 1ns/1ps
module atr_window_timer_test;
    localparam int CNT_W = 24;
    localparam int EARLY = 20;
    localparam int LATE  = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic release_stb = 0, start_bit = 0, stop_cmd = 0, wt_start = 0;
    logic wr_reload = 0, stat_rd = 0;
    logic [CNT_W-1:0] wr_data = '0;
    logic atr_ok, early_flag, timeout_flag, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    atr_window_timer #(.CNT_W(CNT_W), .EARLY_CLKS(EARLY), .LATE_CLKS(LATE)) uut (
        .clk(clk), .rst_n(rst_n), .release_stb(release_stb), .start_bit(start_bit),
        .stop_cmd(stop_cmd), .wt_start(wt_start), .wr_reload(wr_reload),
        .wr_data(wr_data), .stat_rd(stat_rd), .atr_ok(atr_ok),
        .early_flag(early_flag), .timeout_flag(timeout_flag), .irq(irq)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_reload(input int r);
        return (r < 1) ? 1 : r;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_release();
        release_stb = 1; tick(); release_stb = 0;
    endtask

    task automatic start_at(input int k);
        repeat (k - 1) tick();
        start_bit = 1; tick(); start_bit = 0;
    endtask

    task automatic clear_all();
        stop_cmd = 1; stat_rd = 1; tick(); stop_cmd = 0; stat_rd = 0; tick();
        check(!early_flag && !timeout_flag && !irq, "R7 clear", int'(irq), 0);
    endtask

    task automatic atr_trial(input int k);
        do_release();
        if (k < LATE) begin
            start_at(k);
            if (k < EARLY) begin
                check(early_flag == 1, "R3 early flag", int'(early_flag), 1);
                check(atr_ok == 0, "R3 early refused", int'(atr_ok), 0);
                check(irq == 1, "R9 irq on early", int'(irq), 1);
                start_at(EARLY - k);
                check(atr_ok == 1, "R3 later accept", int'(atr_ok), 1);
            end else begin
                check(atr_ok == 1, "R2 accept", int'(atr_ok), 1);
                check(early_flag == 0, "R2 no early", int'(early_flag), 0);
            end
            tick();
            check(atr_ok == 0, "R2 pulse width", int'(atr_ok), 0);
            repeat (LATE) tick();
            check(timeout_flag == 0, "R2 stopped", int'(timeout_flag), 0);
        end else begin
            repeat (LATE - 1) tick();
            check(timeout_flag == 0, "R4 not yet", int'(timeout_flag), 0);
            tick();
            check(timeout_flag == 1, "R4 timeout", int'(timeout_flag), 1);
            check(irq == 1, "R9 irq on timeout", int'(irq), 1);
        end
        clear_all();
    endtask

    task automatic write_reload(input int v);
        wr_reload = 1; wr_data = CNT_W'(v); tick(); wr_reload = 0; tick();
    endtask

    task automatic arm_wait();
        wt_start = 1; tick(); wt_start = 0;
    endtask

    task automatic wait_expect(input int n, input string req);
        if (n > 1) begin
            repeat (n - 1) tick();
            check(timeout_flag == 0, req, int'(timeout_flag), 0);
        end
        tick();
        check(timeout_flag == 1, req, int'(timeout_flag), 1);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        void'($urandom(32'd7321));
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        tick(); tick();
        check(!atr_ok && !early_flag && !timeout_flag && !irq, "R1 reset", int'(irq), 0);
        rst_n = 1; tick();
        check(!atr_ok && !early_flag && !timeout_flag, "R1 after release", int'(timeout_flag), 0);

        // directed window edges (R2, R3, R4)
        atr_trial(EARLY - 1);
        atr_trial(EARLY);
        atr_trial(LATE - 1);
        atr_trial(LATE);

        // start bit exactly at closing edge (R4)
        do_release();
        start_at(LATE);
        check(atr_ok == 0, "R4 late start refused", int'(atr_ok), 0);
        check(timeout_flag == 1, "R4 late start timeout", int'(timeout_flag), 1);
        clear_all();

        // random arrivals
        for (int i = 0; i < 30; i++) begin
            atr_trial(1 + int'($urandom % (LATE + 20)));
        end

        // R7: set wins over simultaneous read, then sticky, then cleared
        do_release();
        repeat (2) tick();
        start_bit = 1; stat_rd = 1; tick(); start_bit = 0; stat_rd = 0;
        check(early_flag == 1, "R7 set wins", int'(early_flag), 1);
        repeat (30) tick();
        check(early_flag == 1, "R7 sticky", int'(early_flag), 1);
        stat_rd = 1; tick(); stat_rd = 0;
        check(early_flag == 0 && irq == 0, "R7 read clears", int'(early_flag), 0);
        clear_all();

        // R8: stop halts without flags
        do_release();
        repeat (10) tick();
        stop_cmd = 1; tick(); stop_cmd = 0;
        repeat (LATE + 10) tick();
        check(timeout_flag == 0, "R8 no timeout", int'(timeout_flag), 0);
        start_at(1);
        check(atr_ok == 0 && early_flag == 0, "R8 start ignored", int'(atr_ok), 0);

        // R5: waiting-time countdown
        write_reload(0);
        arm_wait();
        wait_expect(eff_reload(0), "R5 reload zero");
        clear_all();
        for (int i = 0; i < 8; i++) begin
            int n;
            n = 1 + int'($urandom % 100);
            write_reload(n);
            arm_wait();
            wait_expect(eff_reload(n), "R5 countdown");
            clear_all();
        end

        // R6: start bits reload
        for (int i = 0; i < 4; i++) begin
            int n;
            n = 10 + int'($urandom % 50);
            write_reload(n);
            arm_wait();
            for (int j = 0; j < 5; j++) begin
                start_at(1 + int'($urandom % (n - 1)));
                check(timeout_flag == 0, "R6 reload holds", int'(timeout_flag), 0);
            end
            wait_expect(n, "R6 timeout after last start");
            clear_all();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule